// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register

This block is the host-side control and status word for an attached coprocessor. The host writes it through a single-strobe port and reads its current contents on a combinational read bus. Through it the host can hold the coprocessor halted and pulse two kinds of coprocessor reset. It can also pulse an interrupt request toward the coprocessor and watch a read-only flag that shows a transfer to auxiliary memory is in progress.

Three hardware event inputs feed the register: the coprocessor, the auxiliary-memory engine and the audio interface. A rising edge on any of them latches a sticky status bit, and each status bit has its own enable. The single host interrupt line is active while any latched status has its enable set. A status bit clears only when software writes a 1 to it. Writing 0 leaves it alone, so a read-modify-write that writes zeros to the status positions keeps pending events. The reset and interrupt-request controls clear themselves: each gives a one-cycle pulse and always reads back as 0.

Top module: `cop_ctl_reg`

## Requirements
- R1: After reset, rd_data reads 0x0000 while dma_busy is low, and host_irq, cop_halt, cop_reset_o, cop_soft_reset_o and cop_irq_req are all low.
- R2: A rising edge on src_evt[0] (audio), src_evt[1] (auxiliary memory) or src_evt[2] (coprocessor) sets status bit 3, 5 or 7 after the next clock edge. A level that is held high does not set the bit again once it has been cleared.
- R3: A write with a 1 in bit 3, 5 or 7 clears that status bit. A write with 0 there leaves it unchanged.
- R4: When a rising source edge and a clearing write for the same status bit fall in the same cycle, the status bit ends up set.
- R5: Enable bits 8, 6 and 4 (coprocessor, auxiliary, audio) are ordinary read/write bits. host_irq is high exactly when some status bit is set together with its enable.
- R6: Bit 2 is a read/write halt control, and cop_halt follows its stored value.
- R7: Writing 1 to bit 11 gives a one-cycle pulse on cop_reset_o, and writing 1 to bit 0 gives a one-cycle pulse on cop_soft_reset_o. Both pulses come in the cycle after the write, and both bits always read as 0.
- R8: Writing 1 to bit 1 gives a one-cycle pulse on cop_irq_req in the cycle after the write, and bit 1 always reads as 0.
- R9: Bit 9 always reads as the current dma_busy level, and writes to it have no effect.
- R10: Bits 15 to 12 and bit 10 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| src_evt | input | 3 | Event inputs: [0] audio, [1] auxiliary memory, [2] coprocessor |
| dma_busy | input | 1 | Auxiliary-memory transfer in progress |
| host_irq | output | 1 | Combined interrupt to the host |
| cop_halt | output | 1 | Halt level to the coprocessor |
| cop_reset_o | output | 1 | Full-reset pulse to the coprocessor |
| cop_soft_reset_o | output | 1 | Secondary reset pulse to the coprocessor |
| cop_irq_req | output | 1 | Interrupt-request pulse to the coprocessor |

## Verification
The hardest case to create is a rising source edge that lands in the same clock cycle as a write-one-to-clear of that same status bit. The bench drives the source input and the write strobe on the same falling edge, so both are seen at one rising edge, and then it reads the status back. A related case is a source that stays high after its status has been cleared. The vector table keeps the input high across several writes and shows that the cleared bit stays clear.

// File: rtl/cop_ctl_pkg.sv
package cop_ctl_pkg;
   localparam int unsigned NUM_SRC     = 3;
   localparam int unsigned MIN_REG_W   = 12;
   localparam int unsigned B_SOFT_RST  = 0;
   localparam int unsigned B_IRQ_REQ   = 1;
   localparam int unsigned B_HALT      = 2;
   localparam int unsigned B_SRC_BASE  = 3;
   localparam int unsigned B_DMA       = 9;
   localparam int unsigned B_FULL_RST  = 11;
   localparam int unsigned NUM_PULSE   = 3;

   typedef enum logic [1:0] {
      SRC_AUDIO = 2'd0,
      SRC_AUX   = 2'd1,
      SRC_COP   = 2'd2
   } src_e;

   function automatic int unsigned stat_pos(input int unsigned idx);
      return B_SRC_BASE + 2 * idx;
   endfunction

   function automatic int unsigned mask_pos(input int unsigned idx);
      return B_SRC_BASE + 2 * idx + 1;
   endfunction

   function automatic int unsigned pulse_pos(input int unsigned idx);
      int unsigned p;
      case (idx)
         0:       p = B_SOFT_RST;
         1:       p = B_IRQ_REQ;
         default: p = B_FULL_RST;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/cop_irq_src.sv
module cop_irq_src #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic wr_i,
   input  logic clr_bit_i,
   input  logic mask_bit_i,
   output logic stat_o,
   output logic mask_o,
   output logic req_o
);
   logic evt;
   logic stat_q;
   logic mask_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic src_q;
         always_ff @(posedge clk) begin
            if (!rst_n) src_q <= 1'b0;
            else        src_q <= src_i;
         end
         assign evt = src_i & ~src_q;
      end else begin : g_level
         assign evt = src_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (evt)                   stat_q <= 1'b1;
         else if (wr_i && clr_bit_i) stat_q <= 1'b0;
         if (wr_i) mask_q <= mask_bit_i;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign req_o  = stat_q & mask_q;
endmodule

// File: rtl/cop_pulse_gen.sv
module cop_pulse_gen #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] fire_i,
   output logic [N-1:0] pulse_o
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_pulse
         logic p_q;
         always_ff @(posedge clk) begin
            if (!rst_n) p_q <= 1'b0;
            else        p_q <= fire_i[g];
         end
         assign pulse_o[g] = p_q;
      end
   endgenerate
endmodule

// File: rtl/cop_ctl_reg.sv
module cop_ctl_reg
   import cop_ctl_pkg::*;
#(
   parameter int unsigned REG_W    = 16,
   parameter bit          HALT_RST = 1'b0,
   parameter bit          EDGE_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic [2:0]       src_evt,
   input  logic             dma_busy,
   output logic             host_irq,
   output logic             cop_halt,
   output logic             cop_reset_o,
   output logic             cop_soft_reset_o,
   output logic             cop_irq_req
);
   localparam int unsigned TOP_UNUSED = REG_W - 1;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("cop_ctl_reg: REG_W must hold bit 11");
      end
   endgenerate

   logic [NUM_SRC-1:0]   stat;
   logic [NUM_SRC-1:0]   mask;
   logic [NUM_SRC-1:0]   req;
   logic [NUM_PULSE-1:0] fire;
   logic [NUM_PULSE-1:0] pulse;
   logic                 halt_q;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         cop_irq_src #(.EDGE_MODE(EDGE_MODE)) src_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_evt[s]),
            .wr_i       (wr_en),
            .clr_bit_i  (wr_data[stat_pos(s)]),
            .mask_bit_i (wr_data[mask_pos(s)]),
            .stat_o     (stat[s]),
            .mask_o     (mask[s]),
            .req_o      (req[s])
         );
      end
      for (genvar p = 0; p < NUM_PULSE; p++) begin : g_fire
         assign fire[p] = wr_en & wr_data[pulse_pos(p)];
      end
   endgenerate

   cop_pulse_gen #(.N(NUM_PULSE)) pulse_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire),
      .pulse_o (pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     halt_q <= HALT_RST;
      else if (wr_en) halt_q <= wr_data[B_HALT];
   end

   always_comb begin
      rd_data = '0;
      rd_data[B_HALT] = halt_q;
      rd_data[B_DMA]  = dma_busy;
      for (int i = 0; i < NUM_SRC; i++) begin
         rd_data[stat_pos(i)] = stat[i];
         rd_data[mask_pos(i)] = mask[i];
      end
   end

   logic unused_wr;
   assign unused_wr = ^{wr_data[TOP_UNUSED:B_FULL_RST+1], wr_data[10], wr_data[B_DMA]};

   assign host_irq         = |req;
   assign cop_halt         = halt_q;
   assign cop_soft_reset_o = pulse[0];
   assign cop_irq_req      = pulse[1];
   assign cop_reset_o      = pulse[2];
endmodule

// File: rtl/cop_ctl_chk.sv
module cop_ctl_chk #(
   parameter int unsigned REG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             dma_busy,
   input logic             host_irq,
   input logic             cop_halt,
   input logic             cop_reset_o,
   input logic             cop_soft_reset_o,
   input logic             cop_irq_req
);
   AST_FULL_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_reset_o |-> $past(wr_en && wr_data[11])); // R7
   AST_SOFT_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_soft_reset_o |-> $past(wr_en && wr_data[0])); // R7
   AST_IRQ_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_irq_req |-> $past(wr_en && wr_data[1])); // R8
   AST_STAT_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[7]) |-> $past(wr_en && wr_data[7])); // R3
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[8] && !rd_data[6] && !rd_data[4]) |-> !host_irq); // R5
   AST_HALT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cop_halt) |-> $past(wr_en)); // R6
   AST_DMA_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[9] == dma_busy); // R9
   AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:10] == '0 && rd_data[1:0] == 2'b00); // R10
endmodule

bind cop_ctl_reg cop_ctl_chk #(.REG_W(REG_W)) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .wr_en            (wr_en),
   .wr_data          (wr_data),
   .rd_data          (rd_data),
   .dma_busy         (dma_busy),
   .host_irq         (host_irq),
   .cop_halt         (cop_halt),
   .cop_reset_o      (cop_reset_o),
   .cop_soft_reset_o (cop_soft_reset_o),
   .cop_irq_req      (cop_irq_req)
);

// File: tb/cop_ctl_reg_tb_top.sv
module cop_ctl_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [2:0]  src_evt = '0;
   logic        dma_busy = 1'b0;
   logic        host_irq, cop_halt, cop_reset_o, cop_soft_reset_o, cop_irq_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cop_ctl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_evt(src_evt), .dma_busy(dma_busy),
      .host_irq(host_irq), .cop_halt(cop_halt), .cop_reset_o(cop_reset_o),
      .cop_soft_reset_o(cop_soft_reset_o), .cop_irq_req(cop_irq_req)
   );

   typedef struct packed {
      logic        we;
      logic [15:0] wd;
      logic [2:0]  src;
      logic        dma;
      logic [15:0] exp_rd;
      logic        exp_irq;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0150, 3'b000, 1'b0, 16'h0150, 1'b0}, // R5 enables
      '{1'b0, 16'h0000, 3'b001, 1'b0, 16'h0158, 1'b1}, // R2 audio edge
      '{1'b0, 16'h0000, 3'b001, 1'b0, 16'h0158, 1'b1}, // R2 held
      '{1'b1, 16'h0158, 3'b001, 1'b0, 16'h0150, 1'b0}, // R3 clear, R2 level no reset
      '{1'b0, 16'h0000, 3'b110, 1'b0, 16'h01F0, 1'b1}, // R2 aux+cop
      '{1'b1, 16'h0170, 3'b110, 1'b0, 16'h01D0, 1'b1}, // R3 selective
      '{1'b1, 16'h0000, 3'b110, 1'b0, 16'h0080, 1'b0}, // R5 masked, R3 zero keeps
      '{1'b0, 16'h0000, 3'b110, 1'b1, 16'h0280, 1'b0}, // R9
      '{1'b1, 16'hFFFF, 3'b110, 1'b1, 16'h0354, 1'b0}, // R10 R9 R6
      '{1'b1, 16'h0000, 3'b000, 1'b0, 16'h0000, 1'b0}  // R6 clear
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      wr_en = 1'b1;
      wr_data = d;
      cyc();
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rd", rd_data, 16'h0000);
      chk("R1 outs", {11'd0, host_irq, cop_halt, cop_reset_o, cop_soft_reset_o, cop_irq_req}, 16'h0000);
      rst_n = 1'b1;
      cyc();
      chk("R1 after release", rd_data, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         wr_en = VECS[i].we;
         wr_data = VECS[i].wd;
         src_evt = VECS[i].src;
         dma_busy = VECS[i].dma;
         cyc();
         chk($sformatf("R2-table v%0d rd", i), rd_data, VECS[i].exp_rd);
         chk($sformatf("R5 table v%0d irq", i), {15'd0, host_irq}, {15'd0, VECS[i].exp_irq});
         if (i == 8) chk("R6 halt set", {15'd0, cop_halt}, 16'h0001);
      end
      wr_en = 1'b0;
      wr_data = '0;
      chk("R6 halt clear", {15'd0, cop_halt}, 16'h0000);

      // R4: edge and clearing write together
      src_evt = 3'b000;
      wr(16'h0100);
      chk("R4 pre", rd_data, 16'h0100);
      src_evt = 3'b100;
      wr_en = 1'b1;
      wr_data = 16'h0180;
      cyc();
      wr_en = 1'b0;
      wr_data = '0;
      chk("R4 set wins", rd_data, 16'h0180);
      chk("R4 irq", {15'd0, host_irq}, 16'h0001);
      wr(16'h0080);
      chk("R3 clear cop", rd_data, 16'h0000);
      src_evt = 3'b000;

      // R7 R8: pulses
      wr_en = 1'b1;
      wr_data = 16'h0803;
      cyc();
      wr_en = 1'b0;
      wr_data = '0;
      chk("R7 full reset pulse", {15'd0, cop_reset_o}, 16'h0001);
      chk("R7 soft reset pulse", {15'd0, cop_soft_reset_o}, 16'h0001);
      chk("R8 irq req pulse", {15'd0, cop_irq_req}, 16'h0001);
      chk("R7 R8 readback", rd_data, 16'h0000);
      cyc();
      chk("R7 pulse ends", {14'd0, cop_reset_o, cop_soft_reset_o}, 16'h0000);
      chk("R8 pulse ends", {15'd0, cop_irq_req}, 16'h0000);

      // R6: halt on its own
      wr(16'h0004);
      chk("R6 halt only", {15'd0, cop_halt}, 16'h0001);
      chk("R6 readback", rd_data, 16'h0004);
      wr(16'h0000);
      chk("R6 run", {15'd0, cop_halt}, 16'h0000);

      done = 1'b1;
   end

   initial begin
      int n;
      n = 0;
      while (!done && n < 5000) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule